// File: doc/BRIEF.md
# Prioritized Pin-Multiplexing GPIO Port

This block is an 8-bit I/O port. Each pad can be claimed by a routed SPI channel, by a UART channel, or by plain GPIO. Ownership follows a fixed priority: SPI first, then UART, then GPIO. Software sees two registers on a simple register bus. One is an output-data latch and the other is a direction mask. The block drives each pad's output value and output enable. It also returns synchronized pad inputs to whichever peripheral owns the pad.

The SPI and UART engines live outside the block. They appear only as enable, output, output-enable and input ports. Pads 7..4 are shared by SPI channel 2 and UART channels B and A. Pads 3..2 are shared by SPI channel 1 and UART channel C. Pads 1..0 are GPIO only. Every pad input passes through a two-flop synchronizer before software or a peripheral sees it.

Top module: `pinmux_port`

## Requirements
- R1: After a synchronous reset (`rst` high), the data latch and the direction mask are zero. Every `padOe` bit is 0, `padOut` is 0, and `busRdata` is 0.
- R2: While `spi2En` is 1, pad 4+i carries `spi2Out[i]` with enable `spi2Oe[i]`, where bit 0 is MISO, bit 1 is MOSI, bit 2 is clock and bit 3 is select. While `spi1En` is 1, pad 2+i carries `spi1Out[i]` with enable `spi1Oe[i]`, where bit 0 is clock and bit 1 is select. This holds whatever the UART enables and the registers contain.
- R3: A UART channel owns its two pads when it is enabled and the SPI channel on those pads is not. Channel B uses pads 7 (transmit) and 6 (receive). Channel A uses pads 5 (transmit) and 4 (receive). Channel C uses pads 3 (transmit) and 2 (receive). A transmit pad is driven with `padOe`=1 and the channel's transmit bit. A receive pad has `padOe`=0 and `padOut`=0.
- R4: A pad with no enabled alternate function drives `padOut` from the data latch and `padOe` from the direction bit. Pads 1 and 0 always behave this way.
- R5: A write with `busWrEn` stores `busWdata` at the next clock edge. Address 0 selects the data latch and address 1 selects the direction mask. A read with `busRdEn` loads `busRdata` at that edge from the pre-edge state. Reading address 1 returns the direction mask.
- R6: Reading address 0 returns, for each bit, the latched bit where the direction bit is 1 and the synchronized pad input where it is 0.
- R7: A pad change sampled at clock edge E0 is seen by a read issued at edge E0+2 and not by one issued at E0 or E0+1. The peripheral inputs reflect it after E0+1.
- R8: `spi2In[i]` and `spi1In[i]` equal the synchronized input of their pad while that SPI channel is enabled, and 0 otherwise. `uartARx`, `uartBRx` and `uartCRx` equal the synchronized receive pad while their channel owns it, and 1 otherwise.
- R9: A data write updates the latch even while a peripheral owns the pad. The new value appears on the pad as soon as GPIO regains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 1 | Register select: 0 data, 1 direction |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| spi1En | input | 1 | SPI channel 1 enable |
| spi1Out | input | 2 | SPI 1 outputs (clock, select) |
| spi1Oe | input | 2 | SPI 1 output enables |
| spi1In | output | 2 | SPI 1 inputs from pads |
| spi2En | input | 1 | SPI channel 2 enable |
| spi2Out | input | 4 | SPI 2 outputs (MISO, MOSI, clock, select) |
| spi2Oe | input | 4 | SPI 2 output enables |
| spi2In | output | 4 | SPI 2 inputs from pads |
| uartAEn | input | 1 | UART A enable |
| uartATx | input | 1 | UART A transmit bit |
| uartARx | output | 1 | UART A receive bit |
| uartBEn | input | 1 | UART B enable |
| uartBTx | input | 1 | UART B transmit bit |
| uartBRx | output | 1 | UART B receive bit |
| uartCEn | input | 1 | UART C enable |
| uartCTx | input | 1 | UART C transmit bit |
| uartCRx | output | 1 | UART C receive bit |

## Verification
The hardest case to reach from the ports is a data write that lands while a peripheral owns the pad, combined with a later hand-back to GPIO. The stale latch value must never show on the pad, and the new one must appear in the same cycle the enable drops. The directed part of the stimulus enables UART A, writes the latch and then releases the channel. A random phase toggles enables, SPI direction bits and bus traffic every cycle. A reference model that tracks the two-stage input delay catches any off-by-one in the read path.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int PORT_W      = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdLoad;
    logic rdDir;
  } regStrobe_t;

  // which SPI channel may claim a pad (0 = none)
  function automatic int spiChOf(int pin);
    if (pin >= 4) return 2;
    if (pin >= 2) return 1;
    return 0;
  endfunction

  function automatic int spiBitOf(int pin);
    if (pin >= 4) return pin - 4;
    if (pin >= 2) return pin - 2;
    return 0;
  endfunction

  // UART channel index on a pad: 0 = A, 1 = B, 2 = C, -1 = none
  function automatic int uartChOf(int pin);
    if (pin >= 6) return 1;
    if (pin >= 4) return 0;
    if (pin >= 2) return 2;
    return -1;
  endfunction

  function automatic bit isTxPin(int pin);
    return (pin >= 2) && (pin % 2 == 1);
  endfunction

  function automatic logic [PORT_W-1:0] txMask();
    logic [PORT_W-1:0] m;
    for (int p = 0; p < PORT_W; p++) m[p] = isTxPin(p);
    return m;
  endfunction
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
(
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              spi1En,
  input  logic [1:0]        spi1Out,
  input  logic [1:0]        spi1Oe,
  input  logic              spi2En,
  input  logic [3:0]        spi2Out,
  input  logic [3:0]        spi2Oe,
  input  logic [2:0]        uartEn,
  input  logic [2:0]        uartTx,
  output regStrobe_t        strb,
  output logic [PORT_W-1:0] spiOwn,
  output logic [PORT_W-1:0] uartOwn,
  output logic [PORT_W-1:0] altOut,
  output logic [PORT_W-1:0] altOe
);
  localparam logic [PORT_W-1:0] TX_MASK = txMask();

  logic [PORT_W-1:0] spiEnPin, spiOutPin, spiOePin, uartEnPin, uartTxPin;

  always_comb begin
    strb.wrData = busWrEn && (busAddr == 1'b0);
    strb.wrDir  = busWrEn && (busAddr == 1'b1);
    strb.rdLoad = busRdEn;
    strb.rdDir  = (busAddr == 1'b1);
  end

  for (genvar g = 0; g < PORT_W; g++) begin : gPin
    localparam int SCH = spiChOf(g);
    localparam int SB  = spiBitOf(g);
    localparam int UCH = uartChOf(g);
    localparam bit TX  = isTxPin(g);

    if (SCH == 2) begin : gSpi2
      assign spiEnPin[g]  = spi2En;
      assign spiOutPin[g] = spi2Out[SB];
      assign spiOePin[g]  = spi2Oe[SB];
    end else if (SCH == 1) begin : gSpi1
      assign spiEnPin[g]  = spi1En;
      assign spiOutPin[g] = spi1Out[SB];
      assign spiOePin[g]  = spi1Oe[SB];
    end else begin : gNoSpi
      assign spiEnPin[g]  = 1'b0;
      assign spiOutPin[g] = 1'b0;
      assign spiOePin[g]  = 1'b0;
    end

    if (UCH >= 0) begin : gUart
      assign uartEnPin[g] = uartEn[UCH];
      if (TX) begin : gTx
        assign uartTxPin[g] = uartTx[UCH];
      end else begin : gRx
        assign uartTxPin[g] = 1'b0;
      end
    end else begin : gNoUart
      assign uartEnPin[g] = 1'b0;
      assign uartTxPin[g] = 1'b0;
    end
  end

  // priority: SPI over UART over GPIO
  assign spiOwn  = spiEnPin;
  assign uartOwn = uartEnPin & ~spiEnPin;
  assign altOut  = (spiOwn & spiOutPin) | (uartOwn & uartTxPin);
  assign altOe   = (spiOwn & spiOePin)  | (uartOwn & TX_MASK);
endmodule

// File: rtl/pinmux_dp.sv
module pinmux_dp
  import pinmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [PORT_W-1:0] busWdata,
  input  logic [PORT_W-1:0] padIn,
  input  logic [PORT_W-1:0] spiOwn,
  input  logic [PORT_W-1:0] uartOwn,
  input  logic [PORT_W-1:0] altOut,
  input  logic [PORT_W-1:0] altOe,
  output logic [PORT_W-1:0] busRdata,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] spiInPin,
  output logic [PORT_W-1:0] uartRxPin
);
  localparam logic [PORT_W-1:0] TX_MASK = txMask();

  logic [PORT_W-1:0] dataReg, dirReg, syncIn;
  logic [PORT_W-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      if (strb.wrData) dataReg <= busWdata;
      if (strb.wrDir)  dirReg  <= busWdata;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) syncStage[0] <= '0;
        else     syncStage[0] <= padIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else     syncStage[s] <= syncStage[s-1];
      end
    end
  end
  assign syncIn = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)              busRdata <= '0;
    else if (strb.rdLoad) busRdata <= strb.rdDir ? dirReg
                                    : ((dataReg & dirReg) | (syncIn & ~dirReg));
  end

  for (genvar g = 0; g < PORT_W; g++) begin : gMux
    logic altOwn;
    assign altOwn       = spiOwn[g] | uartOwn[g];
    assign padOut[g]    = altOwn ? altOut[g] : dataReg[g];
    assign padOe[g]     = altOwn ? altOe[g]  : dirReg[g];
    assign spiInPin[g]  = spiOwn[g] & syncIn[g];
    assign uartRxPin[g] = uartOwn[g] ? syncIn[g] : 1'b1;
  end

  // R5
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrData |=> dataReg == $past(busWdata));
  // R5
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    strb.wrDir |=> dirReg == $past(busWdata));
  // R7
  sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> syncStage[0] == $past(padIn));
  // R3
  uart_tx_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ((uartOwn & TX_MASK & ~padOe) == '0));
  // R3
  uart_rx_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ((uartOwn & ~TX_MASK & padOe) == '0));
  // R6
  read_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdLoad && !strb.rdDir && dirReg == '1) |=> busRdata == $past(dataReg));
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  input  logic              spi1En,
  input  logic [1:0]        spi1Out,
  input  logic [1:0]        spi1Oe,
  output logic [1:0]        spi1In,
  input  logic              spi2En,
  input  logic [3:0]        spi2Out,
  input  logic [3:0]        spi2Oe,
  output logic [3:0]        spi2In,
  input  logic              uartAEn,
  input  logic              uartATx,
  output logic              uartARx,
  input  logic              uartBEn,
  input  logic              uartBTx,
  output logic              uartBRx,
  input  logic              uartCEn,
  input  logic              uartCTx,
  output logic              uartCRx
);
  regStrobe_t        strb;
  logic [PORT_W-1:0] spiOwn, uartOwn, altOut, altOe, spiInPin, uartRxPin;

  pinmux_ctrl uCtrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .spi1En(spi1En), .spi1Out(spi1Out), .spi1Oe(spi1Oe),
    .spi2En(spi2En), .spi2Out(spi2Out), .spi2Oe(spi2Oe),
    .uartEn({uartCEn, uartBEn, uartAEn}),
    .uartTx({uartCTx, uartBTx, uartATx}),
    .strb(strb), .spiOwn(spiOwn), .uartOwn(uartOwn),
    .altOut(altOut), .altOe(altOe)
  );

  pinmux_dp uDp (
    .clk(clk), .rst(rst), .strb(strb), .busWdata(busWdata), .padIn(padIn),
    .spiOwn(spiOwn), .uartOwn(uartOwn), .altOut(altOut), .altOe(altOe),
    .busRdata(busRdata), .padOut(padOut), .padOe(padOe),
    .spiInPin(spiInPin), .uartRxPin(uartRxPin)
  );

  assign spi2In  = spiInPin[7:4];
  assign spi1In  = spiInPin[3:2];
  assign uartARx = uartRxPin[4];
  assign uartBRx = uartRxPin[6];
  assign uartCRx = uartRxPin[2];

  // R2
  spi2_owns_chk: assert property (@(posedge clk) disable iff (rst)
    spi2En |-> (padOe[7:4] == spi2Oe && padOut[7:4] == spi2Out));
  // R2
  spi1_owns_chk: assert property (@(posedge clk) disable iff (rst)
    spi1En |-> (padOe[3:2] == spi1Oe && padOut[3:2] == spi1Out));
  // R8
  uart_rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((!uartAEn || spi2En) |-> uartARx) and ((!uartCEn || spi1En) |-> uartCRx));
  // R8
  spi_in_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !spi2En |-> spi2In == 4'b0000);
endmodule

// File: tb/tb_pinmux_port.sv
`timescale 1ns/1ps
module tb_pinmux_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busAddr = 1'b0, busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWdata = '0, busRdata, padIn = '0, padOut, padOe;
  logic spi1En = 1'b0, spi2En = 1'b0;
  logic [1:0] spi1Out = '0, spi1Oe = '0, spi1In;
  logic [3:0] spi2Out = '0, spi2Oe = '0, spi2In;
  logic uartAEn = 0, uartATx = 0, uartARx, uartBEn = 0, uartBTx = 0, uartBRx;
  logic uartCEn = 0, uartCTx = 0, uartCRx;

  int checks = 0, errors = 0;
  logic [7:0] mData = '0, mDir = '0, mS1 = '0, mS2 = '0, mRd = '0;
  string mRdReq = "R1";

  always #4 clk = ~clk;

  pinmux_port dut (.*);

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void expPad(int p, output logic o, output logic oe, output string req);
    logic en, tx, txv;
    if (p >= 4 && spi2En) begin o = spi2Out[p-4]; oe = spi2Oe[p-4]; req = "R2"; return; end
    if ((p == 2 || p == 3) && spi1En) begin o = spi1Out[p-2]; oe = spi1Oe[p-2]; req = "R2"; return; end
    case (p)
      7: begin en = uartBEn; tx = 1; txv = uartBTx; end
      6: begin en = uartBEn; tx = 0; txv = 0; end
      5: begin en = uartAEn; tx = 1; txv = uartATx; end
      4: begin en = uartAEn; tx = 0; txv = 0; end
      3: begin en = uartCEn; tx = 1; txv = uartCTx; end
      2: begin en = uartCEn; tx = 0; txv = 0; end
      default: begin en = 0; tx = 0; txv = 0; end
    endcase
    if (en) begin o = txv; oe = tx; req = "R3"; end
    else begin o = mData[p]; oe = mDir[p]; req = "R4"; end
  endfunction

  task automatic compareAll();
    logic o, oe; string req;
    for (int p = 0; p < 8; p++) begin
      expPad(p, o, oe, req);
      chk(req, $sformatf("padOut[%0d]", p), {7'b0, padOut[p]}, {7'b0, o});
      chk(req, $sformatf("padOe[%0d]", p), {7'b0, padOe[p]}, {7'b0, oe});
    end
    chk(mRdReq, "busRdata", busRdata, mRd);
    chk("R8", "spi2In", {4'b0, spi2In}, spi2En ? {4'b0, mS2[7:4]} : 8'h00);
    chk("R8", "spi1In", {6'b0, spi1In}, spi1En ? {6'b0, mS2[3:2]} : 8'h00);
    chk("R8", "uartARx", {7'b0, uartARx}, {7'b0, (uartAEn && !spi2En) ? mS2[4] : 1'b1});
    chk("R8", "uartBRx", {7'b0, uartBRx}, {7'b0, (uartBEn && !spi2En) ? mS2[6] : 1'b1});
    chk("R8", "uartCRx", {7'b0, uartCRx}, {7'b0, (uartCEn && !spi1En) ? mS2[2] : 1'b1});
  endtask

  task automatic modelEdge();
    if (rst) begin
      mData = 0; mDir = 0; mS1 = 0; mS2 = 0; mRd = 0; mRdReq = "R1";
      return;
    end
    if (busRdEn) begin
      mRd = busAddr ? mDir : ((mData & mDir) | (mS2 & ~mDir));
      mRdReq = busAddr ? "R5" : "R6";
    end
    if (busWrEn && !busAddr) mData = busWdata;
    if (busWrEn && busAddr) mDir = busWdata;
    mS2 = mS1;
    mS1 = padIn;
  endtask

  task automatic cycle();
    #1 compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic busWrite(logic a, logic [7:0] v);
    busAddr = a; busWdata = v; busWrEn = 1;
    cycle();
    busWrEn = 0;
  endtask

  task automatic busRead(logic a);
    busAddr = a; busRdEn = 1;
    cycle();
    busRdEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    padIn = 8'hC3;
    repeat (3) cycle();
    rst = 0;
    // R1: reset state at the ports
    chk("R1", "padOe after reset", padOe, 8'h00);
    chk("R1", "padOut after reset", padOut, 8'h00);
    chk("R1", "busRdata after reset", busRdata, 8'h00);
    busRead(1);
    #1 chk("R1", "direction after reset", busRdata, 8'h00);
    padIn = 8'h00; cycle(); cycle();
    busRead(0);
    #1 chk("R1", "data read after reset", busRdata, 8'h00);

    // R4 / R5: GPIO outputs
    busWrite(1, 8'hFF);
    busWrite(0, 8'hA5);
    #1 chk("R4", "gpio out", padOut, 8'hA5);
    chk("R4", "gpio oe", padOe, 8'hFF);
    busRead(1);
    #1 chk("R5", "dir readback", busRdata, 8'hFF);

    // R6: mixed direction read
    busWrite(1, 8'h0F);
    padIn = 8'h3C; cycle(); cycle();
    busRead(0);
    #1 chk("R6", "mixed read", busRdata, 8'h35);

    // R7: sync latency, reads issued at E0, E0+1, E0+2
    busWrite(1, 8'h00);
    padIn = 8'h00; cycle(); cycle();
    padIn = 8'h5A; busAddr = 0; busRdEn = 1;
    cycle(); #1 chk("R7", "read at E0", busRdata, 8'h00);
    cycle(); #1 chk("R7", "read at E0+1", busRdata, 8'h00);
    cycle(); #1 chk("R7", "read at E0+2", busRdata, 8'h5A);
    busRdEn = 0;

    // R9: write while UART A owns pads 5/4, then hand back
    busWrite(1, 8'hFF);
    busWrite(0, 8'h00);
    uartAEn = 1; uartATx = 0;
    busWrite(0, 8'h30);
    #1 chk("R9", "owned pads hold uart", padOut & 8'h30, 8'h00);
    uartAEn = 0;
    #1 chk("R9", "latch shows on release", padOut & 8'h30, 8'h30);
    cycle();

    // R2 / R3: SPI beats UART
    uartBEn = 1; spi2En = 1; spi2Out = 4'b1010; spi2Oe = 4'b0110;
    #1 chk("R2", "spi2 outs", {4'b0, padOut[7:4]}, 8'h0A);
    chk("R2", "spi2 oes", {4'b0, padOe[7:4]}, 8'h06);
    cycle();
    spi2En = 0; uartBTx = 1;
    #1 chk("R3", "uart B pads oe", {6'b0, padOe[7:6]}, 8'h02);
    cycle();
    uartBEn = 0; cycle();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 0) spi1En = ~spi1En;
      if (r[5:3] == 0) spi2En = ~spi2En;
      if (r[8:6] == 0) uartAEn = ~uartAEn;
      if (r[11:9] == 0) uartBEn = ~uartBEn;
      if (r[14:12] == 0) uartCEn = ~uartCEn;
      r = $urandom;
      spi1Out = r[1:0]; spi1Oe = r[3:2]; spi2Out = r[7:4]; spi2Oe = r[11:8];
      uartATx = r[12]; uartBTx = r[13]; uartCTx = r[14];
      padIn = r[22:15];
      r = $urandom;
      busAddr = r[0]; busWdata = r[8:1];
      busWrEn = (r[10:9] == 0); busRdEn = (r[12:11] != 0);
      cycle();
    end
    busWrEn = 0; busRdEn = 0;
    cycle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule